// File: doc/BRIEF.md
# Write-Invalidate Burst Splitter

This block takes one write burst at a time, a start word address and a length counted in 32-bit words, and cuts it into a stream of chunk descriptors for the bus initiator. Each descriptor carries a word address, a word count and the PCI command code that the chunk must use. When the cache line size is one of the supported values, the invalidate enable is set and the request comes from the main DMA engine, every whole cache line on a line boundary goes out as a memory write-and-invalidate. Partial lines at either end go out as ordinary memory writes. In every other case the whole burst is one ordinary memory write.

A burst is taken with a valid/ready handshake. The line size, the enable and the source are captured when the burst is taken. Descriptors then leave through a valid/ready interface at up to one per cycle. A one-cycle done pulse marks the end of each burst.

Top module: `wrinv_burst_splitter`

## Requirements
- R1: While reset is asserted and right after it is released, `desc_valid_o` and `done_o` are 0 and `req_ready_o` is 1.
- R2: With `line_size_i` equal to 4, 8 or 16, `mwi_en_i` high and `src_i` = 0 (main DMA), each whole line that starts on a line boundary (word address a multiple of the line size) is issued as one descriptor with command 4'b1111 and a length equal to the line size.
- R3: Under the conditions of R2, when the burst starts inside a line, the first descriptor uses command 4'b0111 and runs from the start address up to the next line boundary, or to the end of the burst if that comes first.
- R4: Under the conditions of R2, a trailing piece shorter than a line is issued as a single descriptor with command 4'b0111.
- R5: A `line_size_i` value other than 4, 8 or 16 makes the whole burst one descriptor with command 4'b0111.
- R6: With `mwi_en_i` low, the whole burst is one descriptor with command 4'b0111, whatever the line size.
- R7: Sources 1 (coprocessor DMA), 2 (CPU) and 3 (other) never get command 4'b1111. Their whole burst is one descriptor with command 4'b0111.
- R8: The descriptors of a burst are contiguous. The first one starts at the request address, each next one starts where the previous one ended, no length is 0, and the lengths add up to the request length.
- R9: A descriptor whose `desc_valid_o` is high and `desc_ready_i` is low holds its address, length and command until it is taken. While a burst is in progress `desc_valid_o` stays high, so one descriptor can be taken per cycle.
- R10: `done_o` is high for exactly the one cycle after the last descriptor of a burst is taken. A zero-length burst issues no descriptor, and `done_o` is high in the cycle after the burst is taken.
- R11: `req_ready_o` is low while a burst is in progress, and a request presented then is ignored. The line size, enable and source are sampled only when a burst is taken, so later changes to them have no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Burst request present |
| req_ready_o | output | 1 | Block is idle and can take a burst |
| req_waddr_i | input | 30 | Start address in 32-bit words |
| req_len_i | input | 12 | Burst length in 32-bit words |
| req_src_i | input | 2 | Source: 0 main DMA, 1 coprocessor DMA, 2 CPU, 3 other |
| line_size_i | input | 8 | Cache line size register, in words |
| mwi_en_i | input | 1 | Memory write-and-invalidate enable bit |
| desc_valid_o | output | 1 | Descriptor present |
| desc_ready_i | input | 1 | Descriptor taken when high with valid |
| desc_waddr_o | output | 30 | Chunk start word address |
| desc_len_o | output | 12 | Chunk length in words |
| desc_cmd_o | output | 4 | 4'b0111 memory write, 4'b1111 write-and-invalidate |
| done_o | output | 1 | One-cycle pulse after the last descriptor |

## Verification
Directed bursts cover the aligned whole-line case for each legal line size, a start inside a line with both a head and a tail piece, a single-word burst and a zero-length burst. They also cover an illegal line size, a cleared enable and both non-DMA sources, so each reason for falling back to a plain write can be told apart. Random bursts mix addresses, lengths, line sizes, sources and back-pressure on the descriptor side. That shows whether the chunk boundaries move with the start alignment, and whether a stalled descriptor holds steady. One burst changes the configuration inputs and presents a stray request while busy, which separates configuration captured when the burst is taken from configuration that is used live.

// File: rtl/wrinv_pkg.sv
package wrinv_pkg;
  localparam logic [3:0] CMD_MEM_WR     = 4'b0111;
  localparam logic [3:0] CMD_MEM_WR_INV = 4'b1111;

  typedef enum logic [1:0] {
    SRC_DMA    = 2'd0,
    SRC_COPROC = 2'd1,
    SRC_CPU    = 2'd2,
    SRC_OTHER  = 2'd3
  } src_e;

  typedef struct packed {
    logic       mwi_ok;
    logic [4:0] line_words;
  } line_cfg_t;
endpackage

// File: rtl/wrinv_line_decode.sv
module wrinv_line_decode
  import wrinv_pkg::*;
#(
  parameter int LS_W = 8
) (
  input  logic [LS_W-1:0] line_size_i,
  input  logic            mwi_en_i,
  input  src_e            src_i,
  output line_cfg_t       cfg_o
);
  logic [4:0] lw;

  always_comb begin
    case (line_size_i)
      LS_W'(4):  lw = 5'd4;
      LS_W'(8):  lw = 5'd8;
      LS_W'(16): lw = 5'd16;
      default:   lw = 5'd0;
    endcase
    cfg_o.line_words = lw;
    cfg_o.mwi_ok     = mwi_en_i && (src_i == SRC_DMA) && (lw != 5'd0);
  end
endmodule

// File: rtl/wrinv_chunk_calc.sv
module wrinv_chunk_calc
  import wrinv_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  line_cfg_t        cfg_i,
  input  logic [3:0]       waddr_lo_i,
  input  logic [LEN_W-1:0] rem_i,
  output logic [LEN_W-1:0] chunk_len_o,
  output logic [3:0]       cmd_o
);
  logic [3:0]       mask;
  logic [3:0]       off;
  logic [LEN_W-1:0] to_bound;
  logic [LEN_W-1:0] lw_ext;

  always_comb begin
    mask     = cfg_i.line_words[3:0] - 4'd1;
    off      = waddr_lo_i & mask;
    lw_ext   = LEN_W'(cfg_i.line_words);
    to_bound = lw_ext - LEN_W'(off);
    cmd_o       = CMD_MEM_WR;
    chunk_len_o = rem_i;
    if (cfg_i.mwi_ok) begin
      if (off != 4'd0) begin
        // head piece: stop at next line boundary
        chunk_len_o = (rem_i < to_bound) ? rem_i : to_bound;
      end else if (rem_i >= lw_ext) begin
        chunk_len_o = lw_ext;
        cmd_o       = CMD_MEM_WR_INV;
      end
    end
  end
endmodule

// File: rtl/wrinv_burst_splitter.sv
module wrinv_burst_splitter
  import wrinv_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int LEN_W  = 12,
  parameter int LS_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_waddr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [1:0]        req_src_i,
  input  logic [LS_W-1:0]   line_size_i,
  input  logic              mwi_en_i,
  output logic              desc_valid_o,
  input  logic              desc_ready_i,
  output logic [ADDR_W-1:0] desc_waddr_o,
  output logic [LEN_W-1:0]  desc_len_o,
  output logic [3:0]        desc_cmd_o,
  output logic              done_o
);
  logic              busy_q, done_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [LEN_W-1:0]  rem_q;
  logic [LS_W-1:0]   ls_q;
  logic              en_q;
  src_e              src_q;
  line_cfg_t         cfg;
  logic [LEN_W-1:0]  chunk_len;
  logic [3:0]        chunk_cmd;
  logic              accept, fire, last;

  wrinv_line_decode #(.LS_W(LS_W)) u_decode (
    .line_size_i (ls_q),
    .mwi_en_i    (en_q),
    .src_i       (src_q),
    .cfg_o       (cfg)
  );

  wrinv_chunk_calc #(.LEN_W(LEN_W)) u_chunk (
    .cfg_i       (cfg),
    .waddr_lo_i  (waddr_q[3:0]),
    .rem_i       (rem_q),
    .chunk_len_o (chunk_len),
    .cmd_o       (chunk_cmd)
  );

  assign req_ready_o  = !busy_q;
  assign accept       = req_valid_i && !busy_q;
  assign desc_valid_o = busy_q;
  assign fire         = busy_q && desc_ready_i;
  assign last         = (rem_q == chunk_len);
  assign desc_waddr_o = waddr_q;
  assign desc_len_o   = chunk_len;
  assign desc_cmd_o   = chunk_cmd;
  assign done_o       = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      waddr_q <= '0;
      rem_q   <= '0;
      ls_q    <= '0;
      en_q    <= 1'b0;
      src_q   <= SRC_DMA;
    end else begin
      done_q <= (fire && last) || (accept && (req_len_i == '0));
      if (accept) begin
        busy_q  <= (req_len_i != '0);
        waddr_q <= req_waddr_i;
        rem_q   <= req_len_i;
        ls_q    <= line_size_i;
        en_q    <= mwi_en_i;
        src_q   <= src_e'(req_src_i);
      end else if (fire) begin
        waddr_q <= waddr_q + ADDR_W'(chunk_len);
        rem_q   <= rem_q - chunk_len;
        if (last) busy_q <= 1'b0;
      end
    end
  end

  // R2: invalidate chunks are whole aligned lines
  a_r2_inv_whole_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o && desc_cmd_o == CMD_MEM_WR_INV |->
      ((desc_waddr_o[3:0] & (cfg.line_words[3:0] - 4'd1)) == 4'd0) &&
      (desc_len_o == LEN_W'(cfg.line_words)));

  // R7 / R6 / R5: invalidate only for DMA, enabled, legal size
  a_r7_inv_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o && desc_cmd_o == CMD_MEM_WR_INV |->
      en_q && src_q == SRC_DMA &&
      (ls_q == LS_W'(4) || ls_q == LS_W'(8) || ls_q == LS_W'(16)));

  a_r8_len_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |-> desc_len_o != '0 && desc_len_o <= rem_q);

  a_r8_cmd_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |-> desc_cmd_o == CMD_MEM_WR || desc_cmd_o == CMD_MEM_WR_INV);

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o && !desc_ready_i |=>
      desc_valid_o && $stable(desc_waddr_o) && $stable(desc_len_o) && $stable(desc_cmd_o));

  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !desc_valid_o);

  a_r11_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |-> !req_ready_o);

  a_r11_cfg_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o && $past(desc_valid_o) |-> $stable(ls_q) && $stable(en_q) && $stable(src_q));
endmodule

// File: tb/wrinv_burst_splitter_bench.sv
module wrinv_burst_splitter_bench;
  localparam int ADDR_W = 30;
  localparam int LEN_W  = 12;
  localparam int LS_W   = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_waddr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic [1:0]        req_src = '0;
  logic [LS_W-1:0]   line_size = '0;
  logic              mwi_en = 1'b0;
  logic              desc_valid;
  logic              desc_ready = 1'b0;
  logic [ADDR_W-1:0] desc_waddr;
  logic [LEN_W-1:0]  desc_len;
  logic [3:0]        desc_cmd;
  logic              done;

  int n_vec = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  wrinv_burst_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LS_W(LS_W)) u_wrinv_burst_splitter (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_waddr_i(req_waddr), .req_len_i(req_len), .req_src_i(req_src),
    .line_size_i(line_size), .mwi_en_i(mwi_en),
    .desc_valid_o(desc_valid), .desc_ready_i(desc_ready),
    .desc_waddr_o(desc_waddr), .desc_len_o(desc_len), .desc_cmd_o(desc_cmd),
    .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int line_words(input int ls);
    if (ls == 4 || ls == 8 || ls == 16) return ls;
    return 0;
  endfunction

  // expected next chunk from the requirements
  task automatic model(input longint waddr, input int rem, input int lw, input bit ok,
                       output int len, output int cmd, output bit head);
    int off;
    len = rem; cmd = 4'b0111; head = 1'b0;
    if (ok) begin
      off = int'(waddr % lw);
      if (off != 0) begin
        head = 1'b1;
        len = (rem < lw - off) ? rem : lw - off;
      end else if (rem >= lw) begin
        len = lw; cmd = 4'b1111;
      end
    end
  endtask

  task automatic run_burst(input longint addr, input int len, input int ls,
                           input bit en, input int src, input bit disturb);
    longint wa;
    int     rem, lw, elen, ecmd, guard;
    bit     ok, head, stall;
    string  tag;
    logic [ADDR_W-1:0] s_a;
    logic [LEN_W-1:0]  s_l;
    logic [3:0]        s_c;
    lw = line_words(ls);
    ok = en && src == 0 && lw != 0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11", "ready when idle", req_ready, 1);
    req_valid = 1'b1;
    req_waddr = ADDR_W'(addr);
    req_len   = LEN_W'(len);
    req_src   = 2'(src);
    line_size = LS_W'(ls);
    mwi_en    = en;
    desc_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    if (len == 0) begin
      chk(done == 1'b1, "R10", "done after empty burst", done, 1);
      chk(desc_valid == 1'b0, "R10", "no descriptor for empty burst", desc_valid, 0);
      @(negedge clk);
      chk(done == 1'b0, "R10", "done one cycle", done, 0);
      return;
    end
    if (disturb) begin
      chk(req_ready == 1'b0, "R11", "ready low while busy", req_ready, 0);
      req_valid = 1'b1;
      req_waddr = ~req_waddr;
      req_len   = 12'd7;
      line_size = (ls == 4) ? 8'd16 : 8'd4;
      mwi_en    = ~en;
      req_src   = ~req_src;
    end
    wa = addr; rem = len; stall = 1'b0; guard = 0;
    while (rem > 0 && guard < 4000) begin
      guard++;
      if (guard > 1) req_valid = 1'b0;
      model(wa, rem, lw, ok, elen, ecmd, head);
      if (!ok) tag = (src != 0) ? "R7" : (!en ? "R6" : "R5");
      else if (ecmd == 4'b1111) tag = "R2";
      else if (head) tag = "R3";
      else tag = "R4";
      chk(desc_valid == 1'b1, "R9", "valid held during burst", desc_valid, 1);
      if (stall) begin
        chk(desc_waddr == s_a && desc_len == s_l && desc_cmd == s_c, "R9",
            "descriptor held under stall", longint'(desc_waddr), longint'(s_a));
      end
      desc_ready = ($urandom % 4) != 0;
      if (desc_ready) begin
        chk(desc_waddr == ADDR_W'(wa), "R8", "chunk address", desc_waddr, longint'(ADDR_W'(wa)));
        chk(desc_len == LEN_W'(elen), tag, "chunk length", desc_len, elen);
        chk(desc_cmd == 4'(ecmd), tag, "chunk command", desc_cmd, ecmd);
        wa = wa + elen; rem = rem - elen; stall = 1'b0;
      end else begin
        s_a = desc_waddr; s_l = desc_len; s_c = desc_cmd; stall = 1'b1;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    desc_ready = 1'b0;
    if (guard >= 4000) chk(1'b0, "R8", "burst never ended", guard, 0);
    chk(done == 1'b1, "R10", "done after last chunk", done, 1);
    chk(desc_valid == 1'b0, "R10", "idle after last chunk", desc_valid, 0);
    @(negedge clk);
    chk(done == 1'b0, "R10", "done one cycle", done, 0);
    chk(desc_valid == 1'b0, "R11", "stray request ignored", desc_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    int ls_pick;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(desc_valid == 1'b0 && done == 1'b0, "R1", "outputs in reset", desc_valid, 0);
    chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(desc_valid == 1'b0 && done == 1'b0 && req_ready == 1'b1, "R1",
        "state after reset", desc_valid, 0);

    run_burst(64'h100, 16, 4, 1, 0, 0);   // R2 four lines
    run_burst(64'h203, 20, 8, 1, 0, 0);   // R3 head, R2 line, R4 tail
    run_burst(64'h340, 32, 16, 1, 0, 0);  // R2
    run_burst(64'h345, 5, 16, 1, 0, 0);   // R3 head ends with burst
    run_burst(64'h400, 3, 4, 1, 0, 0);    // R4 short tail only
    run_burst(64'h500, 30, 12, 1, 0, 0);  // R5
    run_burst(64'h500, 30, 8, 0, 0, 0);   // R6
    run_burst(64'h500, 30, 8, 1, 1, 0);   // R7 coprocessor
    run_burst(64'h500, 30, 8, 1, 2, 0);   // R7 CPU
    run_burst(64'h600, 0, 8, 1, 0, 0);    // R10 empty
    run_burst(64'h601, 1, 4, 1, 0, 0);    // single word
    run_burst(64'h3FFF_FFF8, 24, 8, 1, 0, 0); // address wrap
    run_burst(64'h702, 40, 8, 1, 0, 1);   // R11 disturb
    run_burst(64'h800, 24, 4, 0, 0, 1);   // R11 disturb enables

    for (int i = 0; i < 300; i++) begin
      ls_pick = $urandom % 5;
      run_burst(longint'($urandom % (1 << ADDR_W)),
                ($urandom % 8 == 0) ? int'($urandom % 200) : int'($urandom % 40),
                (ls_pick == 0) ? 4 : (ls_pick == 1) ? 8 : (ls_pick == 2) ? 16 : int'($urandom % 256),
                ($urandom % 4) != 0,
                ($urandom % 3 == 0) ? int'($urandom % 4) : 0,
                ($urandom % 10) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule